// File: doc/BRIEF.md
# Pixel Point-Operation Unit with Post-Shift

This block sits on an incoming 8-bit pixel stream and applies one point operation per clock. The first operand is the pixel itself. The second operand comes from a held 8-bit register, which is written from a configuration data bus whenever a load enable is high. A 10-bit microcode word selects the operation in its low seven bits and a post-shift in its upper three bits.

Logical operations are coded as a two-input truth table, so every one of the sixteen two-input boolean functions is available. Three arithmetic codes give A+B, A−B and B−A, truncated to 8 bits. The shift stage works on the result of any operation and moves it up to three places right (zero fill) or left (bits shifted out are lost). The unit is pipelined and accepts a new pixel and microcode on every clock.

Top module: `pix_alu_shift`

## Requirements
- R1: While rst_ni is low, pix_o is 0 and the B operand register is 0.
- R2: The pixel and microcode sampled at clock edge k produce their result on pix_o after edge k+1, one result per clock with no gaps.
- R3: The B operand register takes cfg_data_i at each rising edge where b_load_i is high and holds otherwise. A pixel sampled at edge k uses the B value present after edge k, including a load at that same edge.
- R4: When microcode bits 2:0 are 000, result bit i is microcode bit 6, 5, 4 or 3 for (A bit i, B bit i) equal to 00, 01, 10 or 11 respectively (for example 0001000 is AND, 0011000 is A, 0101000 is B, 0110000 is XOR).
- R5: Microcode 0110001 gives A+B, 1001010 gives A−B and 1001100 gives B−A, all modulo 256.
- R6: Any low-7-bit code that has nonzero bits 2:0 and is not one of the three arithmetic codes gives 0.
- R7: Shift codes (microcode bits 9:7) 001, 010 and 011 shift the ALU result right by 1, 2 and 3, filling with zeros.
- R8: Shift codes 100, 101 and 110 shift the ALU result left by 1, 2 and 3, discarding bits above bit 7.
- R9: Shift codes 000 and 111 pass the ALU result unshifted.
- R10: The shift is applied to arithmetic results in the same way as to logical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Incoming pixel, operand A |
| ucode_i | input | 10 | Microcode: bits 9:7 shift, bits 6:0 operation |
| cfg_data_i | input | 8 | Configuration data feeding the B register |
| b_load_i | input | 1 | Load enable for the B register |
| pix_o | output | 8 | Processed pixel |

## Verification
Every result is due two rising edges after its pixel and microcode are presented, while a B load takes effect for the pixel sampled at the same edge. The bench's reference model carries each expected value and its requirement tag through a two-entry pipeline of its own and compares pix_o at the falling edge after every clock, so a result arriving one cycle early or late fails. All sixteen logical codes and the three arithmetic codes are swept against all eight shift codes with random operands and random B reloads, and a set of undefined codes follows.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int PIX_W     = 8;
  localparam int OP_W      = 7;
  localparam int SH_W      = 3;
  localparam int UC_W      = OP_W + SH_W;
  localparam int MAX_SHIFT = 3;

  localparam logic [OP_W-1:0] OP_ADD   = 7'b0110001;
  localparam logic [OP_W-1:0] OP_A_SUB = 7'b1001010;
  localparam logic [OP_W-1:0] OP_B_SUB = 7'b1001100;

  typedef struct packed {
    logic [SH_W-1:0] sh;
    logic [OP_W-1:0] op;
  } ucode_t;
endpackage

// File: rtl/pa_operand_reg.sv
module pa_operand_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pa_point_alu.sv
module pa_point_alu
  import pa_pkg::*;
#(
  parameter int W = PIX_W
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    y_o
);
  logic [3:0]   tt;
  logic [W-1:0] y_logic;
  logic         is_logic;

  assign tt       = op_i[6:3];
  assign is_logic = (op_i[2:0] == 3'b000);

  // truth table: tt[3] for pair 00 ... tt[0] for pair 11
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pair;
    assign pair       = {a_i[i], b_i[i]};
    assign y_logic[i] = tt[2'd3 - pair];
  end

  always_comb begin
    if (is_logic) y_o = y_logic;
    else begin
      unique case (op_i)
        OP_ADD:   y_o = a_i + b_i;
        OP_A_SUB: y_o = a_i - b_i;
        OP_B_SUB: y_o = b_i - a_i;
        default:  y_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pa_post_shift.sv
module pa_post_shift
  import pa_pkg::*;
#(
  parameter int W = PIX_W
) (
  input  logic [W-1:0]    d_i,
  input  logic [SH_W-1:0] code_i,
  output logic [W-1:0]    d_o
);
  localparam int NCAND = MAX_SHIFT + 1;

  logic [W-1:0] right_c [NCAND];
  logic [W-1:0] left_c  [NCAND];

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    assign right_c[k] = d_i >> k;
    assign left_c[k]  = d_i << k;
  end

  // 0xx: right by xx; 1xx (xx<3): left by xx+1; 111: pass
  always_comb begin
    if (!code_i[2])             d_o = right_c[code_i[1:0]];
    else if (code_i[1:0] == 2'b11) d_o = d_i;
    else                        d_o = left_c[code_i[1:0] + 2'd1];
  end
endmodule

// File: rtl/pix_alu_shift.sv
module pix_alu_shift
  import pa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [UC_W-1:0]  ucode_i,
  input  logic [PIX_W-1:0] cfg_data_i,
  input  logic             b_load_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [PIX_W-1:0] a_q;
  ucode_t           uc_q;
  logic [PIX_W-1:0] b_q;
  logic [PIX_W-1:0] alu_y;
  logic [PIX_W-1:0] sh_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      uc_q <= '0;
    end else begin
      a_q  <= pix_i;
      uc_q <= ucode_t'(ucode_i);
    end
  end

  pa_operand_reg #(.W(PIX_W)) u_breg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (b_load_i),
    .d_i    (cfg_data_i),
    .q_o    (b_q)
  );

  pa_point_alu #(.W(PIX_W)) u_alu (
    .a_i  (a_q),
    .b_i  (b_q),
    .op_i (uc_q.op),
    .y_o  (alu_y)
  );

  pa_post_shift #(.W(PIX_W)) u_shift (
    .d_i    (alu_y),
    .code_i (uc_q.sh),
    .d_o    (sh_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= sh_y;
  end
endmodule

// File: rtl/pa_chk.sv
module pa_chk
  import pa_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             b_load_i,
  input logic [PIX_W-1:0] cfg_data_i,
  input logic [PIX_W-1:0] b_q_i,
  input logic [UC_W-1:0]  uc_q_i,
  input logic [PIX_W-1:0] pix_o_i
);
  logic undef_op;
  assign undef_op = (uc_q_i[2:0] != 3'b000) && (uc_q_i[6:0] != OP_ADD) &&
                    (uc_q_i[6:0] != OP_A_SUB) && (uc_q_i[6:0] != OP_B_SUB);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pix_o_i == '0 && b_q_i == '0));

  assert_b_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_load_i |=> (b_q_i == $past(cfg_data_i)));

  assert_b_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_load_i |=> $stable(b_q_i));

  assert_undef_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_op |=> (pix_o_i == '0));

  assert_right_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uc_q_i[9] && uc_q_i[8:7] != 2'b00) |=> (pix_o_i[PIX_W-1] == 1'b0));

  assert_left_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uc_q_i[9] && uc_q_i[8:7] != 2'b11) |=> (pix_o_i[0] == 1'b0));
endmodule

bind pix_alu_shift pa_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .b_load_i   (b_load_i),
  .cfg_data_i (cfg_data_i),
  .b_q_i      (b_q),
  .uc_q_i     (uc_q),
  .pix_o_i    (pix_o)
);

// File: tb/pix_alu_shift_test.sv
module pix_alu_shift_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [7:0] pix_i = '0;
  logic [9:0] ucode_i = '0;
  logic [7:0] cfg_data_i = '0;
  logic       b_load_i = 1'b0;
  logic [7:0] pix_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R2";

  always #2 clk_i = ~clk_i;

  pix_alu_shift uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .ucode_i(ucode_i),
    .cfg_data_i(cfg_data_i), .b_load_i(b_load_i), .pix_o(pix_o)
  );

  function automatic logic [7:0] ref_op(input logic [9:0] uc, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    int sh;
    case (uc[6:0])
      7'b0000000: r = 8'h00;
      7'b1111000: r = 8'hFF;
      7'b0011000: r = a;
      7'b0101000: r = b;
      7'b1100000: r = ~a;
      7'b1010000: r = ~b;
      7'b0001000: r = a & b;
      7'b0010000: r = a & ~b;
      7'b0100000: r = ~a & b;
      7'b0111000: r = a | b;
      7'b1011000: r = a | ~b;
      7'b1101000: r = ~a | b;
      7'b1110000: r = ~(a & b);
      7'b1000000: r = ~(a | b);
      7'b0110000: r = a ^ b;
      7'b1001000: r = ~(a ^ b);
      7'b0110001: r = 8'((int'(a) + int'(b)) % 256);
      7'b1001010: r = 8'((int'(a) - int'(b) + 256) % 256);
      7'b1001100: r = 8'((int'(b) - int'(a) + 256) % 256);
      default:    r = 8'h00;
    endcase
    sh = int'(uc[9:7]);
    if (sh >= 1 && sh <= 3) r = r >> sh;
    else if (sh >= 4 && sh <= 6) r = 8'((int'(r) << (sh - 3)) % 256);
    return r;
  endfunction

  // reference pipeline: value and tag of the pending and the visible result
  logic [7:0] b_m = '0;
  logic [7:0] stage_m = '0, out_m = '0;
  string stage_tag = "R1", out_tag = "R1";

  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      b_m = '0; stage_m = '0; out_m = '0;
      stage_tag = "R1"; out_tag = "R1";
    end else begin
      if (b_load_i) b_m = cfg_data_i;
      out_m = stage_m;
      out_tag = stage_tag;
      stage_m = ref_op(ucode_i, pix_i, b_m);
      stage_tag = tag;
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      checks++;
      if (!rst_ni) begin
        if (pix_o !== 8'h00) begin
          failures++;
          $display("FAIL R1 reset output: actual=%0h expected=0", pix_o);
        end
      end else if (pix_o !== out_m) begin
        failures++;
        $display("FAIL %s: actual=%0h expected=%0h", out_tag, pix_o, out_m);
      end
    end
  end

  task automatic step(input logic [7:0] p, input logic [9:0] uc,
                      input logic ld, input logic [7:0] cd, input string t);
    @(negedge clk_i);
    pix_i = p; ucode_i = uc; b_load_i = ld; cfg_data_i = cd; tag = t;
  endtask

  function automatic string tag_for(input logic [6:0] op, input logic [2:0] sh);
    bit arith = (op[2:0] != 3'b000);
    if (arith && sh != 3'd0) return "R10";
    if (sh == 3'd0) return arith ? "R5" : "R4";
    if (sh <= 3'd3) return "R7";
    if (sh <= 3'd6) return "R8";
    return "R9";
  endfunction

  localparam logic [6:0] CODES [19] = '{
    7'b0000000, 7'b1111000, 7'b0011000, 7'b0101000, 7'b1100000,
    7'b1010000, 7'b0001000, 7'b0010000, 7'b0100000, 7'b0111000,
    7'b1011000, 7'b1101000, 7'b1110000, 7'b1000000, 7'b0110000,
    7'b1001000, 7'b0110001, 7'b1001010, 7'b1001100};

  localparam logic [6:0] BAD [6] = '{
    7'b0000001, 7'b1111111, 7'b0110010, 7'b1001011, 7'b0000100, 7'b1010101};

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: pass-through stream, latency and throughput
    for (int i = 0; i < 8; i++) step(8'(i * 37 + 5), 10'b000_0011000, 1'b0, 8'h00, "R2");
    // R3: load B, then hold with changing bus
    step(8'h12, 10'b000_0101000, 1'b1, 8'hA5, "R3");
    for (int i = 0; i < 4; i++) step(8'h34, 10'b000_0101000, 1'b0, 8'(i * 11 + 1), "R3");
    step(8'h0F, 10'b000_0110001, 1'b1, 8'h3C, "R3");
    step(8'h0F, 10'b000_0110001, 1'b0, 8'hFF, "R3");
    // R4 R5 R7 R8 R9 R10: every code against every shift
    for (int c = 0; c < 19; c++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 4; k++)
          step(8'($urandom), {3'(s), CODES[c]}, 1'($urandom), 8'($urandom),
               tag_for(CODES[c], 3'(s)));
    // R6: undefined codes
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < 4; k++)
        step(8'($urandom), {3'(k), BAD[c]}, 1'($urandom), 8'($urandom), "R6");
    // arithmetic corners: wrap and borrow (R5)
    step(8'hFF, 10'b000_0110001, 1'b1, 8'h01, "R5");
    step(8'h00, 10'b000_1001010, 1'b0, 8'h00, "R5");
    step(8'h01, 10'b000_1001100, 1'b1, 8'h00, "R5");
    step(8'h80, 10'b110_0110001, 1'b1, 8'h80, "R10");
    repeat (4) step(8'h00, 10'b000_0011000, 1'b0, 8'h00, "R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk_i) begin
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule